// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects interrupt request lines from two local groups of eight lines each and from a third group of eight mappable sources. Each local group has a status view and a mask, and it drives one interrupt output toward the CPU whenever any masked status bit is set. The mappable sources share one status view, and two independent masks qualify it. The first masked result folds into one fixed bit of local group 0, and the second folds into one fixed bit of local group 1. The result is a two-level cascade: software that sees the folded bit examines the map status next.

Software reaches the block through a simple 32-bit register bus. A write strobe carries an address and data, and read data is combinational from the address. The block also holds two timer interrupt latches. Each latch sets on a rising edge of its timer input, drives its own output, and is cleared by writing a one to its bit of a clear register.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, all four mask registers read zero, both CPU interrupt outputs are low and both timer outputs are low.
- R2: Word offset 0x00 reads the local group 0 status in bits 7:0. Each bit follows the matching `l0_req` line one clock after sampling. Bit 7 is also the cascade bit (see R6).
- R3: Word offset 0x08 reads the local group 1 status in bits 7:0 from `l1_req`, with the same one-clock latency. Bit 3 is also the cascade bit (see R7).
- R4: The masks are read/write in bits 7:0 at these offsets: local 0 at 0x04, local 1 at 0x0C, map mask 0 at 0x14, map mask 1 at 0x18. Bits 31:8 of every read return zero, and writing zero back is accepted.
- R5: `cpu_irq[g]` is high exactly when local group g status ANDed with its mask is nonzero. Index 0 is local group 0 and index 1 is local group 1.
- R6: Offset 0x10 reads the sampled `map_req` lines. Local group 0 status bit 7 is the OR of `l0_req[7]` and any bit set in (map status AND map mask 0).
- R7: Local group 1 status bit 3 is the OR of `l1_req[3]` and any bit set in (map status AND map mask 1).
- R8: `timer_irq[t]` goes high one clock after a rising edge of `timer_in[t]` is sampled. It stays high while the input falls, until it is cleared.
- R9: A write to offset 0x1C clears timer latch 0 when data bit 0 is one and timer latch 1 when data bit 1 is one. The value 0x3 clears both. Zero bits leave their latch untouched, and the offset reads zero.
- R10: When a rising timer edge and a clear of the same latch land in the same clock, the latch ends up set.
- R11: Writes to the status offsets 0x00, 0x08 and 0x10 change no mask, no status and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l0_req | input | 8 | Raw request lines of local group 0 |
| l1_req | input | 8 | Raw request lines of local group 1 |
| map_req | input | 8 | Raw mappable request lines |
| timer_in | input | 2 | Timer event inputs, rising-edge sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address, word aligned (bits 4:2 select the register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 2 | CPU interrupt per local group |
| timer_irq | output | 2 | Timer latch outputs |

## Verification
Request lines pass through one sampling register, so status, map status and `cpu_irq` change one clock after a request is driven. Mask writes and timer clears take effect at the clock edge that carries the strobe. Timer latches respond at the edge where the rising input is first sampled. The bench drives every input on the falling edge and checks at the next falling edge, so each expected value is due exactly one rising edge after its stimulus. Reads are taken a short delay after the address is set, because read data is combinational.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int CIC_ADDR_W = 5;

  typedef enum logic [2:0] {
    RA_L0_STAT   = 3'd0,
    RA_L0_MASK   = 3'd1,
    RA_L1_STAT   = 3'd2,
    RA_L1_MASK   = 3'd3,
    RA_MAP_STAT  = 3'd4,
    RA_MAP_MASK0 = 3'd5,
    RA_MAP_MASK1 = 3'd6,
    RA_TMR_CLR   = 3'd7
  } reg_idx_e;

  localparam int MSK_L0    = 0;
  localparam int MSK_L1    = 1;
  localparam int MSK_MAP0  = 2;
  localparam int MSK_MAP1  = 3;
  localparam int NUM_MASKS = 4;

  function automatic reg_idx_e mask_slot(input int m);
    case (m)
      MSK_L0:   return RA_L0_MASK;
      MSK_L1:   return RA_L1_MASK;
      MSK_MAP0: return RA_MAP_MASK0;
      default:  return RA_MAP_MASK1;
    endcase
  endfunction

endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cic_sampler.sv
module cic_sampler #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/cic_mask_reg.sv
module cic_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb q_d = wr_en ? wdata : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/cic_timer_latch.sv
module cic_timer_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tin,
  input  logic clr,
  output logic irq
);
  logic prev_q, prev_d;
  logic irq_q, irq_d;
  logic rise;

  always_comb begin
    rise   = tin & ~prev_q;
    prev_d = tin;
    // a fresh edge outranks a clear in the same cycle
    irq_d  = rise | (irq_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int TMR_N       = 2,
  parameter int DATA_W      = 32,
  parameter int L0_CASC_BIT = 7,
  parameter int L1_CASC_BIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GRP_W-1:0]      l0_req,
  input  logic [GRP_W-1:0]      l1_req,
  input  logic [GRP_W-1:0]      map_req,
  input  logic [TMR_N-1:0]      timer_in,
  input  logic                  bus_wr,
  input  logic [CIC_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [1:0]            cpu_irq,
  output logic [TMR_N-1:0]      timer_irq
);
  localparam int RAW_W = 3 * GRP_W;

  logic             rst_sync_n;
  logic [RAW_W-1:0] raw_q;
  logic [GRP_W-1:0] map_q;
  logic [GRP_W-1:0] mask_q [NUM_MASKS];
  logic [GRP_W-1:0] grp_stat [2];
  logic [1:0]       casc_hit;
  logic [TMR_N-1:0] tmr_clr;
  logic [GRP_W-1:0] rd_grp;
  reg_idx_e         slot;

  cic_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  cic_sampler #(.W(RAW_W)) u_smp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({map_req, l1_req, l0_req}),
    .q     (raw_q)
  );

  assign slot  = reg_idx_e'(bus_addr[CIC_ADDR_W-1:2]);
  assign map_q = raw_q[2*GRP_W +: GRP_W];

  for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
    logic we;
    assign we = bus_wr && (slot == mask_slot(m));
    cic_mask_reg #(.W(GRP_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (we),
      .wdata (bus_wdata[GRP_W-1:0]),
      .q     (mask_q[m])
    );
  end

  // second level: each masked view of the map group folds into one local bit
  assign casc_hit[0] = |(map_q & mask_q[MSK_MAP0]);
  assign casc_hit[1] = |(map_q & mask_q[MSK_MAP1]);

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int CB = (g == 0) ? L0_CASC_BIT : L1_CASC_BIT;
    localparam int MI = (g == 0) ? MSK_L0 : MSK_L1;
    assign grp_stat[g] = raw_q[g*GRP_W +: GRP_W] | (GRP_W'(casc_hit[g]) << CB);
    assign cpu_irq[g]  = |(grp_stat[g] & mask_q[MI]);
  end

  assign tmr_clr = (bus_wr && slot == RA_TMR_CLR) ? bus_wdata[TMR_N-1:0] : '0;

  for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
    cic_timer_latch u_lat (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tin   (timer_in[t]),
      .clr   (tmr_clr[t]),
      .irq   (timer_irq[t])
    );
  end

  always_comb begin
    rd_grp = '0;
    case (slot)
      RA_L0_STAT:   rd_grp = grp_stat[0];
      RA_L0_MASK:   rd_grp = mask_q[MSK_L0];
      RA_L1_STAT:   rd_grp = grp_stat[1];
      RA_L1_MASK:   rd_grp = mask_q[MSK_L1];
      RA_MAP_STAT:  rd_grp = map_q;
      RA_MAP_MASK0: rd_grp = mask_q[MSK_MAP0];
      RA_MAP_MASK1: rd_grp = mask_q[MSK_MAP1];
      default:      rd_grp = '0;
    endcase
  end

  assign bus_rdata = DATA_W'(rd_grp);
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int TMR_N       = 2,
  parameter int DATA_W      = 32,
  parameter int L0_CASC_BIT = 7,
  parameter int L1_CASC_BIT = 3
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_wr,
  input logic [4:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [TMR_N-1:0]  timer_in,
  input logic [TMR_N-1:0]  timer_irq,
  input logic [1:0]        cpu_irq,
  input logic [1:0]        casc
);
  logic [TMR_N-1:0] seen_q;
  logic [2:0]       idx;

  assign idx = bus_addr[4:2];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) seen_q <= '0;
    else         seen_q <= timer_in;
  end

  // R5: a zero written to a local mask silences that group's output
  p_mask_zero_quiet_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && idx == 3'd1 && bus_wdata[7:0] == 8'h00) |=> !cpu_irq[0]);

  // R6
  p_casc_l0_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (idx == 3'd0 && casc[0]) |-> bus_rdata[L0_CASC_BIT]);

  // R7
  p_casc_l1_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (idx == 3'd2 && casc[1]) |-> bus_rdata[L1_CASC_BIT]);

  for (genvar t = 0; t < TMR_N; t++) begin : g_t
    // R8 and R10: a rising edge always leaves the latch set
    p_tmr_set_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (timer_in[t] && !seen_q[t]) |=> timer_irq[t]);
    // R8: held until cleared
    p_tmr_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (timer_irq[t] && !(bus_wr && idx == 3'd7 && bus_wdata[t])) |=> timer_irq[t]);
    // R9
    p_tmr_clr_r9: assert property (@(posedge clk) disable iff (!srst_n)
      (bus_wr && idx == 3'd7 && bus_wdata[t] && !(timer_in[t] && !seen_q[t]))
      |=> !timer_irq[t]);
  end
endmodule

bind cascade_irq_ctrl cic_checker #(
  .TMR_N(TMR_N), .DATA_W(DATA_W), .L0_CASC_BIT(L0_CASC_BIT), .L1_CASC_BIT(L1_CASC_BIT)
) u_chk (
  .clk       (clk),
  .srst_n    (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .timer_in  (timer_in),
  .timer_irq (timer_irq),
  .cpu_irq   (cpu_irq),
  .casc      (casc_hit)
);

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  l0_req, l1_req, map_req;
  logic [1:0]  timer_in;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu_irq;
  logic [1:0]  timer_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cascade_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .l0_req(l0_req), .l1_req(l1_req), .map_req(map_req),
    .timer_in(timer_in), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .timer_irq(timer_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m0s [3];
    m0s[0] = 8'hFF; m0s[1] = 8'h5A; m0s[2] = 8'h00;
    rst_n = 1'b0; l0_req = '0; l1_req = '0; map_req = '0; timer_in = '0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 l0 mask", 5'h04, 32'h0);
    rd_chk("R1 l1 mask", 5'h0C, 32'h0);
    rd_chk("R1 map mask0", 5'h14, 32'h0);
    rd_chk("R1 map mask1", 5'h18, 32'h0);
    check("R1 cpu_irq", {30'b0, cpu_irq}, 32'h0);
    check("R1 timer_irq", {30'b0, timer_irq}, 32'h0);

    // R4 mask read/write, upper bits zero, zero write back
    wr(5'h04, 32'hFFFF_FFA5); rd_chk("R4 l0 mask", 5'h04, 32'hA5);
    wr(5'h0C, 32'h1234_5678); rd_chk("R4 l1 mask", 5'h0C, 32'h78);
    wr(5'h14, 32'h0000_01C3); rd_chk("R4 map mask0", 5'h14, 32'hC3);
    wr(5'h18, 32'hFFFF_FF3C); rd_chk("R4 map mask1", 5'h18, 32'h3C);
    for (int i = 0; i < 4; i++) begin
      wr(5'(4 + 8 * (i % 2) + 16 * (i / 2) - ((i == 3) ? 4 : 0) + ((i == 3) ? 4 : 0)), 32'h0);
    end
    wr(5'h18, 32'h0);
    rd_chk("R4 l0 zero", 5'h04, 32'h0);
    rd_chk("R4 l1 zero", 5'h0C, 32'h0);
    rd_chk("R4 mm0 zero", 5'h14, 32'h0);
    rd_chk("R4 mm1 zero", 5'h18, 32'h0);

    // R2 / R5 sweep of local group 0
    for (int k = 0; k < 3; k++) begin
      wr(5'h04, {24'b0, m0s[k]});
      for (int v = 0; v < 256; v++) begin
        @(negedge clk); l0_req = 8'(v);
        @(negedge clk);
        rd_chk("R2 l0 status", 5'h00, 32'(v));
        check("R5 cpu_irq0", {31'b0, cpu_irq[0]}, {31'b0, |(8'(v) & m0s[k])});
      end
    end
    l0_req = '0;

    // R3 / R5 sweep of local group 1
    wr(5'h0C, 32'h96);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); l1_req = 8'(v);
      @(negedge clk);
      rd_chk("R3 l1 status", 5'h08, 32'(v));
      check("R5 cpu_irq1", {31'b0, cpu_irq[1]}, {31'b0, |(8'(v) & 8'h96)});
    end
    l1_req = '0;

    // R6 / R7 cascade sweep
    wr(5'h04, 32'h80); wr(5'h0C, 32'h08);
    wr(5'h14, 32'h3C); wr(5'h18, 32'hC3);
    for (int v = 0; v < 256; v++) begin
      logic h0, h1;
      h0 = |(8'(v) & 8'h3C);
      h1 = |(8'(v) & 8'hC3);
      @(negedge clk); map_req = 8'(v);
      @(negedge clk);
      rd_chk("R6 map status", 5'h10, 32'(v));
      rd_chk("R6 l0 cascade", 5'h00, {24'b0, h0, 7'b0});
      rd_chk("R7 l1 cascade", 5'h08, {28'b0, h1, 3'b0});
      check("R6 cpu_irq0", {31'b0, cpu_irq[0]}, {31'b0, h0});
      check("R7 cpu_irq1", {31'b0, cpu_irq[1]}, {31'b0, h1});
    end

    // R11 writes to status offsets ignored
    map_req = 8'h04; l0_req = 8'h01;
    wr(5'h00, 32'hFF); wr(5'h08, 32'hFF); wr(5'h10, 32'hFF);
    rd_chk("R11 l0 mask", 5'h04, 32'h80);
    rd_chk("R11 l1 mask", 5'h0C, 32'h08);
    rd_chk("R11 mm0", 5'h14, 32'h3C);
    rd_chk("R11 mm1", 5'h18, 32'hC3);
    rd_chk("R11 l0 status", 5'h00, 32'h81);
    rd_chk("R11 map status", 5'h10, 32'h04);
    check("R11 cpu_irq", {30'b0, cpu_irq}, 32'h1);

    // R8 timer set and hold
    @(negedge clk); timer_in = 2'b01;
    @(negedge clk);
    check("R8 set t0", {30'b0, timer_irq}, 32'h1);
    timer_in = 2'b00;
    repeat (3) @(negedge clk);
    check("R8 hold t0", {30'b0, timer_irq}, 32'h1);

    // R9 clear semantics
    wr(5'h1C, 32'h2);
    check("R9 zero bit no effect", {30'b0, timer_irq}, 32'h1);
    wr(5'h1C, 32'h1);
    check("R9 clear t0", {30'b0, timer_irq}, 32'h0);
    @(negedge clk); timer_in = 2'b11;
    @(negedge clk);
    check("R8 set both", {30'b0, timer_irq}, 32'h3);
    timer_in = 2'b00;
    wr(5'h1C, 32'h3);
    check("R9 clear both", {30'b0, timer_irq}, 32'h0);
    rd_chk("R9 clear reads zero", 5'h1C, 32'h0);

    // R10 set wins over clear in the same cycle
    @(negedge clk);
    timer_in = 2'b10; bus_wr = 1'b1; bus_addr = 5'h1C; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 set wins", {30'b0, timer_irq}, 32'h2);
    timer_in = 2'b00;
    wr(5'h1C, 32'h2);
    check("R10 later clear", {30'b0, timer_irq}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule